// File: doc/BRIEF.md
# Chained System Bus Arbiter

This block decides which on-chip bus master of an I/O device chip may use the chip's internal bus. Each transfer of the internal bus ends on a shared, multiplexed 32-bit system bus, so the chip must own the system bus before any internal grant is given. The chip gets that ownership in one of two ways. As the central arbiter, it decides ownership itself among external requesters (other chips on the same bus) and itself. As a chained subordinate, it raises a request to an external arbiter and waits for that arbiter's grant.

Straps are sampled once after reset. They set the operating mode, one of four base address slots (up to four such chips can share one bus), and whether the chip drives or receives the system reset. Internal requests are served round-robin. A per-master fail input from error logging removes a master from arbitration for good, until the next reset.

The controller is one state machine with these states:
- INIT: two cycles after reset, with no grants.
- IDLE: waiting for a request.
- WAIT: chained mode, requesting upstream.
- WIN: the system bus is owned and the internal master is being picked.
- GRANT: an internal master owns the internal bus.
- EXT: central mode, an external requester owns the system bus.
- REL: a one-cycle release.

The transitions are:
- INIT→IDLE after two cycles.
- IDLE→EXT when in central mode and any external request is present.
- IDLE→WIN when in central mode and an enabled local request is present.
- IDLE→WAIT when in chained mode and an enabled local request is present.
- WAIT→WIN on the upstream grant.
- WIN→GRANT when an enabled request is still present.
- WIN→REL when no enabled request remains.
- GRANT→REL on xfer_done.
- EXT→REL when the granted external request drops.
- REL→IDLE always.

Top module: `sysbus_chain_arbiter`

## Requirements
- R1: The strap inputs are captured on the first clock edge after reset is released. The outputs cfg_slot (equal to the strap_slot value, 0 to 3), cfg_central and cfg_rst_drive report the captured values. Later changes of the straps have no effect until the next reset.
- R2: When cfg_central is 1, the block arbitrates the system bus itself and up_req stays 0. When it is 0, the block requests the system bus through up_req.
- R3: cfg_rst_drive is 1 when the chip drives the system reset and 0 when it receives it, taken from strap_rst_drive.
- R4: An internal grant (mst_gnt) rises only after a cycle in which sysbus_own was already 1 and no internal grant was given. sysbus_own stays 1 while a grant is held.
- R5: A pulse on mst_fail[i] locks master i out permanently, until reset. A request from a locked master alone produces no system bus activity and no grant.
- R6: Internal requests are served round-robin. The search starts at the master after the one last granted (index 0 after reset) and wraps from N_MST-1 to 0. mst_gnt is one-hot, with bit i standing for master i.
- R7: In central mode, external requests beat the local chip. Among them, the lowest index wins. ext_gnt is one-hot and is held as long as the granted ext_req bit stays 1.
- R8: A grant is held until xfer_done is seen. It is then followed by exactly one cycle with no grant, sysbus_own at 0 and up_req at 0.
- R9: For the two cycles after reset is released, no grant is given and sysbus_own stays 0, even with requests pending.
- R10: In chained mode, ext_req is ignored and ext_gnt stays 0. up_req stays 1 and no internal grant is given until up_gnt arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| strap_slot | input | 2 | Base address slot strap |
| strap_central | input | 1 | 1 = central arbiter, 0 = chained |
| strap_rst_drive | input | 1 | 1 = drive system reset, 0 = receive it |
| mst_req | input | N_MST | Internal master requests |
| mst_fail | input | N_MST | Per-master error lockout pulses |
| xfer_done | input | 1 | Current internal owner has finished |
| mst_gnt | output | N_MST | One-hot internal grant |
| ext_req | input | N_EXT | External requesters (central mode) |
| ext_gnt | output | N_EXT | One-hot external grant (central mode) |
| up_req | output | 1 | Request to the external arbiter (chained mode) |
| up_gnt | input | 1 | Grant from the external arbiter |
| sysbus_own | output | 1 | The chip owns the system bus for its own masters |
| cfg_slot | output | 2 | Latched address slot |
| cfg_central | output | 1 | Latched mode |
| cfg_rst_drive | output | 1 | Latched reset direction |

## Verification
The hardest case to reach from the ports is a locked-out master. The lockout must stay hidden until reset, and an earlier grant must not make it seem to work by chance. The stimulus pulses the fail input first and then requests with only that master. It holds the request over several cycles and watches that the system bus is never taken. It then adds a second requester and checks that only the second one is served. Finally it resets the block and shows that the same lone request is granted again. The strap capture is checked by changing the straps one cycle after reset is released.

// File: rtl/sba_pkg.sv
package sba_pkg;
    typedef enum logic [2:0] {
        ST_INIT,
        ST_IDLE,
        ST_WAIT,
        ST_WIN,
        ST_GRANT,
        ST_EXT,
        ST_REL
    } sba_state_e;
endpackage

// File: rtl/sba_cfg_latch.sv
module sba_cfg_latch #(
    parameter int SLOT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [SLOT_W-1:0] strap_slot,
    input  logic              strap_central,
    input  logic              strap_rst_drive,
    output logic [SLOT_W-1:0] cfg_slot,
    output logic              cfg_central,
    output logic              cfg_rst_drive
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_slot      <= '0;
            cfg_central   <= 1'b0;
            cfg_rst_drive <= 1'b0;
        end else if (cap) begin
            cfg_slot      <= strap_slot;
            cfg_central   <= strap_central;
            cfg_rst_drive <= strap_rst_drive;
        end
    end
endmodule

// File: rtl/sba_lockout.sv
module sba_lockout #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] fail,
    output logic [N-1:0] locked
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) locked <= '0;
        else        locked <= locked | fail;
    end

    // R5
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((locked & ~$past(locked)) == '0) || ($past(fail) != '0));
endmodule

// File: rtl/sba_rr_pick.sv
module sba_rr_pick #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] ptr,
    output logic [IDX_W-1:0] pick,
    output logic             found
);
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = 0; k < N; k++) begin
            if (!found && req[(int'(ptr) + k) % N]) begin
                found = 1'b1;
                pick  = IDX_W'((int'(ptr) + k) % N);
            end
        end
    end
endmodule

// File: rtl/sba_prio_pick.sv
module sba_prio_pick #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] onehot,
    output logic         any
);
    always_comb begin
        onehot = '0;
        any    = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (!any && req[k]) begin
                onehot[k] = 1'b1;
                any       = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sysbus_chain_arbiter.sv
module sysbus_chain_arbiter
    import sba_pkg::*;
#(
    parameter int N_MST  = 4,
    parameter int N_EXT  = 3,
    parameter int SLOT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] strap_slot,
    input  logic              strap_central,
    input  logic              strap_rst_drive,
    input  logic [N_MST-1:0]  mst_req,
    input  logic [N_MST-1:0]  mst_fail,
    input  logic              xfer_done,
    output logic [N_MST-1:0]  mst_gnt,
    input  logic [N_EXT-1:0]  ext_req,
    output logic [N_EXT-1:0]  ext_gnt,
    output logic              up_req,
    input  logic              up_gnt,
    output logic              sysbus_own,
    output logic [SLOT_W-1:0] cfg_slot,
    output logic              cfg_central,
    output logic              cfg_rst_drive
);
    localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_MST - 1);

    sba_state_e       st_q, st_d;
    logic             init_cnt_q;
    logic [IDX_W-1:0] owner_q, rr_ptr_q, pick;
    logic [N_EXT-1:0] ext_sel_q, ext_pick_oh;
    logic [N_MST-1:0] locked, elig;
    logic             elig_any, ext_any, cap;

    assign cap  = (st_q == ST_INIT) && !init_cnt_q;
    assign elig = mst_req & ~locked;

    sba_cfg_latch #(.SLOT_W(SLOT_W)) i_cfg (
        .clk(clk), .rst_n(rst_n), .cap(cap),
        .strap_slot(strap_slot), .strap_central(strap_central),
        .strap_rst_drive(strap_rst_drive),
        .cfg_slot(cfg_slot), .cfg_central(cfg_central),
        .cfg_rst_drive(cfg_rst_drive)
    );

    sba_lockout #(.N(N_MST)) i_lock (
        .clk(clk), .rst_n(rst_n), .fail(mst_fail), .locked(locked)
    );

    sba_rr_pick #(.N(N_MST), .IDX_W(IDX_W)) i_rr (
        .req(elig), .ptr(rr_ptr_q), .pick(pick), .found(elig_any)
    );

    sba_prio_pick #(.N(N_EXT)) i_prio (
        .req(ext_req), .onehot(ext_pick_oh), .any(ext_any)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= ST_INIT;
            init_cnt_q <= 1'b0;
            owner_q    <= '0;
            rr_ptr_q   <= '0;
            ext_sel_q  <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_INIT) init_cnt_q <= 1'b1;
            if (st_q == ST_WIN && elig_any) begin
                owner_q  <= pick;
                rr_ptr_q <= (pick == LAST_IDX) ? '0 : pick + 1'b1;
            end
            if (st_q == ST_IDLE && cfg_central && ext_any)
                ext_sel_q <= ext_pick_oh;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_INIT:  if (init_cnt_q) st_d = ST_IDLE;
            ST_IDLE: begin
                if (cfg_central) begin
                    if (ext_any)       st_d = ST_EXT;
                    else if (elig_any) st_d = ST_WIN;
                end else if (elig_any) begin
                    st_d = ST_WAIT;
                end
            end
            ST_WAIT:  if (up_gnt) st_d = ST_WIN;
            ST_WIN:   st_d = elig_any ? ST_GRANT : ST_REL;
            ST_GRANT: if (xfer_done) st_d = ST_REL;
            ST_EXT:   if ((ext_req & ext_sel_q) == '0) st_d = ST_REL;
            ST_REL:   st_d = ST_IDLE;
            default:  st_d = ST_INIT;
        endcase
    end

    // outputs
    always_comb begin
        mst_gnt    = '0;
        ext_gnt    = '0;
        sysbus_own = 1'b0;
        up_req     = 1'b0;
        unique case (st_q)
            ST_WAIT:  up_req = !cfg_central;
            ST_WIN: begin
                sysbus_own = 1'b1;
                up_req     = !cfg_central;
            end
            ST_GRANT: begin
                sysbus_own       = 1'b1;
                up_req           = !cfg_central;
                mst_gnt[owner_q] = 1'b1;
            end
            ST_EXT:   ext_gnt = ext_sel_q;
            default: ;
        endcase
    end

    // R4
    own_before_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|mst_gnt) |-> ($past(sysbus_own) && $past(mst_gnt) == '0));

    // R4
    own_during_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_gnt != '0) |-> sysbus_own);

    // R5
    no_locked_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|mst_gnt) |-> ((mst_gnt & $past(locked)) == '0));

    // R6
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mst_gnt));

    // R7
    ext_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ext_gnt) && !((ext_gnt != '0) && (mst_gnt != '0)));

    // R8
    hold_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(|mst_gnt) |-> ($past(xfer_done) && !up_req && !sysbus_own));

    // R1
    cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_INIT) |=> $stable({cfg_slot, cfg_central, cfg_rst_drive}));

    // R10
    chain_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_req && !up_gnt && mst_gnt == '0 && !sysbus_own) |=> (up_req && mst_gnt == '0));

    // R10
    chain_no_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_central |-> (ext_gnt == '0));
endmodule

// File: tb/test_sysbus_chain_arbiter.sv
module test_sysbus_chain_arbiter;
    localparam int CLK_P = 10;
    localparam int NM = 4;
    localparam int NE = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    strap_slot = '0;
    logic          strap_central = 1'b1, strap_rst_drive = 1'b0;
    logic [NM-1:0] mst_req = '0, mst_fail = '0, mst_gnt;
    logic          xfer_done = 1'b0;
    logic [NE-1:0] ext_req = '0, ext_gnt;
    logic          up_req, up_gnt = 1'b0, sysbus_own;
    logic [1:0]    cfg_slot;
    logic          cfg_central, cfg_rst_drive;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_P/2) clk = ~clk;

    sysbus_chain_arbiter #(.N_MST(NM), .N_EXT(NE), .SLOT_W(2)) i_sysbus_chain_arbiter (
        .clk(clk), .rst_n(rst_n), .strap_slot(strap_slot),
        .strap_central(strap_central), .strap_rst_drive(strap_rst_drive),
        .mst_req(mst_req), .mst_fail(mst_fail), .xfer_done(xfer_done),
        .mst_gnt(mst_gnt), .ext_req(ext_req), .ext_gnt(ext_gnt),
        .up_req(up_req), .up_gnt(up_gnt), .sysbus_own(sysbus_own),
        .cfg_slot(cfg_slot), .cfg_central(cfg_central), .cfg_rst_drive(cfg_rst_drive)
    );

    // round-robin table: {request mask, expected grant}, starting from pointer 0
    localparam logic [7:0] RR_VEC [8] = '{
        {4'b1111, 4'b0001}, {4'b1111, 4'b0010}, {4'b1001, 4'b1000},
        {4'b0110, 4'b0010}, {4'b0010, 4'b0010}, {4'b1111, 4'b0100},
        {4'b0001, 4'b0001}, {4'b1000, 4'b1000}
    };

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(logic central, logic [1:0] slot, logic rdrv);
        @(negedge clk);
        rst_n = 1'b0;
        mst_req = '0; mst_fail = '0; ext_req = '0; up_gnt = 1'b0; xfer_done = 1'b0;
        strap_central = central; strap_slot = slot; strap_rst_drive = rdrv;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        strap_central = ~central; strap_slot = ~slot; strap_rst_drive = ~rdrv;
        @(negedge clk);
    endtask

    task automatic run_txn(logic [3:0] req, logic [3:0] exp);
        @(negedge clk); mst_req = req;
        @(negedge clk);
        check("R4 win before grant", {sysbus_own, mst_gnt}, {1'b1, 4'b0000});
        @(negedge clk);
        check("R6 round-robin grant", mst_gnt, exp);
        xfer_done = 1'b1;
        @(negedge clk);
        check("R8 release cycle", {mst_gnt, sysbus_own, up_req}, 6'b0);
        xfer_done = 1'b0; mst_req = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        // R9: requests pending through reset, no grant for two cycles
        strap_central = 1'b1; strap_slot = 2'd3; strap_rst_drive = 1'b1;
        mst_req = 4'b1111;
        repeat (3) @(negedge clk);
        check("R9 reset state", {mst_gnt, ext_gnt, sysbus_own, up_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 init cycle 0", {mst_gnt, sysbus_own}, 0);
        strap_slot = 2'd0; strap_rst_drive = 1'b0; strap_central = 1'b0;
        @(negedge clk);
        check("R9 init cycle 1", {mst_gnt, sysbus_own}, 0);
        @(negedge clk);
        check("R4 win after init", {sysbus_own, mst_gnt}, {1'b1, 4'b0000});
        @(negedge clk);
        check("R6 first grant", mst_gnt, 4'b0001);
        check("R1 slot latched", cfg_slot, 2'd3);
        check("R3 reset drive latched", cfg_rst_drive, 1'b1);
        check("R2 central latched", cfg_central, 1'b1);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0; mst_req = '0;

        // R6: table of round-robin vectors
        do_reset(1'b1, 2'd1, 1'b0);
        for (int i = 0; i < 8; i++) run_txn(RR_VEC[i][7:4], RR_VEC[i][3:0]);
        check("R1 slot ignores later strap", cfg_slot, 2'd1);
        check("R3 receive reset", cfg_rst_drive, 1'b0);

        // R7: external priority over local, lowest index first, held while requested
        do_reset(1'b1, 2'd0, 1'b0);
        @(negedge clk); ext_req = 3'b110; mst_req = 4'b0001;
        @(negedge clk);
        check("R7 ext lowest index wins", {ext_gnt, mst_gnt, sysbus_own}, {3'b010, 4'b0, 1'b0});
        @(negedge clk);
        check("R7 ext grant held", ext_gnt, 3'b010);
        ext_req = 3'b100;
        @(negedge clk);
        check("R7 ext release", ext_gnt, 3'b000);
        @(negedge clk);
        @(negedge clk);
        check("R7 next ext grant", ext_gnt, 3'b100);
        ext_req = '0;
        repeat (4) @(negedge clk);
        check("R7 local served last", mst_gnt, 4'b0001);
        check("R2 no upstream request in central", up_req, 1'b0);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0; mst_req = '0;

        // R10: chained mode
        do_reset(1'b0, 2'd2, 1'b1);
        check("R2 chained latched", cfg_central, 1'b0);
        check("R1 slot 2", cfg_slot, 2'd2);
        @(negedge clk); mst_req = 4'b0010; ext_req = 3'b111;
        @(negedge clk);
        check("R10 upstream request", {up_req, ext_gnt, mst_gnt}, {1'b1, 3'b0, 4'b0});
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R10 wait for upstream grant", {up_req, sysbus_own, mst_gnt, ext_gnt}, {1'b1, 1'b0, 4'b0, 3'b0});
        end
        up_gnt = 1'b1;
        @(negedge clk);
        check("R4 chained win", {sysbus_own, mst_gnt}, {1'b1, 4'b0});
        @(negedge clk);
        check("R10 chained grant", {mst_gnt, up_req}, {4'b0010, 1'b1});
        xfer_done = 1'b1;
        @(negedge clk);
        check("R8 chained release drops up_req", {up_req, mst_gnt, sysbus_own}, 0);
        xfer_done = 1'b0; mst_req = '0; ext_req = '0; up_gnt = 1'b0;

        // R5: lockout until reset
        do_reset(1'b1, 2'd0, 1'b0);
        @(negedge clk); mst_fail = 4'b0100;
        @(negedge clk); mst_fail = '0; mst_req = 4'b0100;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R5 locked master ignored", {sysbus_own, mst_gnt}, 0);
        end
        mst_req = 4'b0110;
        @(negedge clk);
        @(negedge clk);
        check("R5 other master served", mst_gnt, 4'b0010);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R8 grant held without done", mst_gnt, 4'b0010);
        end
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0; mst_req = '0;
        do_reset(1'b1, 2'd0, 1'b0);
        run_txn(4'b0100, 4'b0100);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule